// File: doc/BRIEF.md
# Sign-magnitude multiply/divide sequencer

This unit performs fixed-point multiplication and division on 36-bit sign-magnitude words, advancing one bit per clock. State lives in two registers. The accumulator is 38 bits: a sign, two overflow bits (Q, then P) and a 35-bit magnitude. The multiplier-quotient register is 36 bits: a sign and a 35-bit magnitude. A caller presents a storage operand, a step count and an operation code, then pulses the start strobe. A multiply or divide then runs for the given number of steps, and `done_o` marks the end of every accepted operation.

Each sign is kept apart from its magnitude throughout. The step count alone sets how many multiplier or quotient bits are processed. A divide whose dividend is too large is refused before any register changes. Two load operations write the storage operand into either register, so a host can set up the dividend or the multiplier.

Top module: `sm_muldiv`

## Requirements
- R1: After reset the accumulator, the multiplier-quotient register, `busy_o`, `done_o` and `dchk_o` are all zero.
- R2: Operation code 2 loads the accumulator: bit 37 takes operand bit 35, bits 36:35 (Q, P) are cleared, and bits 34:0 take operand bits 34:0. Operation code 3 loads the whole 36-bit operand into the multiplier-quotient register. The written value is visible, with `done_o` high, in the cycle after the start is accepted.
- R3: A multiply (code 0) or divide (code 1) with a step count of zero changes neither register. It clears `dchk_o` even if the divide would otherwise be refused, and `done_o` pulses in the next cycle.
- R4: For each multiply step, if the multiplier-quotient register's bit 0 is 1, the operand magnitude (bits 34:0) is added modulo 2^37 to the accumulator bits 36:0. The pair is then shifted right by one place, and accumulator bit 0 enters register bit 34. At the end, the sign written to both accumulator bit 37 and register bit 35 is the XOR of the register's sign and operand bit 35.
- R5: A multiply with a nonzero step count and either a zero operand magnitude or a zero register magnitude clears accumulator bits 36:0 and register bits 34:0, writes the XOR sign into both sign bits, and finishes in one cycle.
- R6: A divide with a nonzero step count whose accumulator bits 36:0 are greater than or equal to the operand magnitude sets `dchk_o`, leaves both registers untouched, and pulses `done_o` in the next cycle.
- R7: For each divide step, the 37-bit accumulator magnitude and the 35-bit register magnitude are shifted left by one place as a pair, and register bit 34 moves into accumulator bit 0. If the accumulator magnitude is then at least the divisor, the divisor is subtracted and register bit 0 is set. At the end, register bit 35 is the dividend sign XOR the divisor sign, and accumulator bit 37 is the dividend sign.
- R8: An operation that runs N steps performs exactly one step per clock. `busy_o` is high during the steps. `done_o` is high for a single cycle, N+1 cycles after the start is accepted, and `busy_o` is low in that cycle.
- R9: A start strobe is ignored while `busy_o` is high: it changes neither the registers nor the sequence length.
- R10: `dchk_o` holds its value between operations. Every accepted start rewrites it: 1 only for a refused divide, 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled when not busy |
| op_i | input | 2 | 0 multiply, 1 divide, 2 load accumulator, 3 load multiplier-quotient |
| steps_i | input | 8 | Step count for multiply and divide |
| operand_i | input | 36 | Storage operand: bit 35 sign, bits 34:0 magnitude |
| acc_o | output | 38 | Accumulator: bit 37 sign, 36 Q, 35 P, 34:0 magnitude |
| mq_o | output | 36 | Multiplier-quotient register: bit 35 sign, 34:0 magnitude |
| busy_o | output | 1 | A multiply or divide is stepping |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| dchk_o | output | 1 | Divide-check flag |

## Verification
Two things can fall in the same cycle: a new start strobe and a step of a sequence already running. The bench provokes this by pulsing a load-accumulator operation in the middle of a multiply. It then checks three things against the reference model, which ignores the strobe: the final product, the run length, and a single `done_o` pulse. The other collision is between the refusal test and the step count. The bench issues a zero-count divide with an oversized dividend and requires the divide-check flag to stay clear. It also issues a divide whose dividend equals the divisor and requires a refusal with unchanged registers.

// File: rtl/sm_muldiv_pkg.sv
package sm_muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_DIV = 2'd1,
    OP_LDA = 2'd2,
    OP_LDM = 2'd3
  } sm_op_e;
endpackage

// File: rtl/sm_muldiv_step.sv
module sm_muldiv_step #(
  parameter int MAG_W = 35
) (
  input  logic             div_i,
  input  logic [MAG_W+1:0] acc_i,
  input  logic [MAG_W-1:0] mq_i,
  input  logic [MAG_W-1:0] sr_i,
  output logic [MAG_W+1:0] acc_o,
  output logic [MAG_W-1:0] mq_o
);
  localparam int AW = MAG_W + 2;

  logic [AW-1:0]    sr_ext;
  logic [AW-1:0]    mul_sum;
  logic [AW-1:0]    div_sh;
  logic             div_ge;
  logic [AW-1:0]    mul_acc, div_acc;
  logic [MAG_W-1:0] mul_mq, div_mq;

  assign sr_ext = {2'b00, sr_i};

  always_comb begin
    mul_sum = mq_i[0] ? acc_i + sr_ext : acc_i;
    mul_acc = mul_sum >> 1;
    mul_mq  = {mul_sum[0], mq_i[MAG_W-1:1]};
  end

  always_comb begin
    div_sh  = {acc_i[AW-2:0], mq_i[MAG_W-1]};
    div_ge  = div_sh >= sr_ext;
    div_acc = div_ge ? div_sh - sr_ext : div_sh;
    div_mq  = {mq_i[MAG_W-2:0], div_ge};
  end

  assign acc_o = div_i ? div_acc : mul_acc;
  assign mq_o  = div_i ? div_mq  : mul_mq;
endmodule

// File: rtl/sm_muldiv_ctrl.sv
module sm_muldiv_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             launch_i,
  input  logic [CNT_W-1:0] steps_i,
  output logic             busy_o,
  output logic             last_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (accept_i) begin
        if (launch_i) begin
          busy_q <= 1'b1;
          cnt_q  <= steps_i;
        end else begin
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CNT_W'(1));
  assign done_o = done_q;

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  assert_last_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> done_q && !busy_q);
  assert_count_down_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last_o |=> busy_q && (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_accept_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> !busy_q);
endmodule

// File: rtl/sm_muldiv.sv
module sm_muldiv
  import sm_muldiv_pkg::*;
#(
  parameter int MAG_W = 35,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [CNT_W-1:0] steps_i,
  input  logic [MAG_W:0]   operand_i,
  output logic [MAG_W+2:0] acc_o,
  output logic [MAG_W:0]   mq_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             dchk_o
);
  localparam int AW = MAG_W + 2;  // accumulator magnitude incl. Q, P
  localparam int AS = MAG_W + 2;  // accumulator sign bit

  sm_op_e op;
  logic [AS:0]      acc_q;
  logic [MAG_W:0]   mq_q;
  logic [MAG_W-1:0] sr_q;
  logic             acc_sgn_q, mq_sgn_q, div_q, dchk_q;
  logic             busy, last;
  logic             accept, nz, mul_zero, div_big;
  logic             launch, refuse, mzero_hit, prod_sgn;
  logic [AW-1:0]    nxt_acc;
  logic [MAG_W-1:0] nxt_mq;

  assign op        = sm_op_e'(op_i);
  assign accept    = start_i && !busy;
  assign nz        = steps_i != '0;
  assign mul_zero  = (operand_i[MAG_W-1:0] == '0) || (mq_q[MAG_W-1:0] == '0);
  assign div_big   = acc_q[AW-1:0] >= {2'b00, operand_i[MAG_W-1:0]};
  assign prod_sgn  = mq_q[MAG_W] ^ operand_i[MAG_W];
  assign launch    = accept && nz &&
                     (((op == OP_MUL) && !mul_zero) || ((op == OP_DIV) && !div_big));
  assign refuse    = accept && nz && (op == OP_DIV) && div_big;
  assign mzero_hit = accept && nz && (op == OP_MUL) && mul_zero;

  sm_muldiv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .launch_i (launch),
    .steps_i  (steps_i),
    .busy_o   (busy),
    .last_o   (last),
    .done_o   (done_o)
  );

  sm_muldiv_step #(.MAG_W(MAG_W)) u_step (
    .div_i (div_q),
    .acc_i (acc_q[AW-1:0]),
    .mq_i  (mq_q[MAG_W-1:0]),
    .sr_i  (sr_q),
    .acc_o (nxt_acc),
    .mq_o  (nxt_mq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      mq_q      <= '0;
      sr_q      <= '0;
      acc_sgn_q <= 1'b0;
      mq_sgn_q  <= 1'b0;
      div_q     <= 1'b0;
      dchk_q    <= 1'b0;
    end else if (accept) begin
      dchk_q <= refuse;
      unique case (op)
        OP_LDA: acc_q <= {operand_i[MAG_W], 2'b00, operand_i[MAG_W-1:0]};
        OP_LDM: mq_q  <= operand_i;
        OP_MUL: begin
          if (mzero_hit) begin
            acc_q <= {prod_sgn, {AW{1'b0}}};
            mq_q  <= {prod_sgn, {MAG_W{1'b0}}};
          end else if (launch) begin
            acc_q     <= {1'b0, acc_q[AW-1:0]};
            mq_q      <= {1'b0, mq_q[MAG_W-1:0]};
            sr_q      <= operand_i[MAG_W-1:0];
            acc_sgn_q <= prod_sgn;
            mq_sgn_q  <= prod_sgn;
            div_q     <= 1'b0;
          end
        end
        OP_DIV: begin
          if (launch) begin
            acc_q     <= {1'b0, acc_q[AW-1:0]};
            mq_q      <= {1'b0, mq_q[MAG_W-1:0]};
            sr_q      <= operand_i[MAG_W-1:0];
            acc_sgn_q <= acc_q[AS];
            mq_sgn_q  <= acc_q[AS] ^ operand_i[MAG_W];
            div_q     <= 1'b1;
          end
        end
        default: ;
      endcase
    end else if (busy) begin
      acc_q <= {last && acc_sgn_q, nxt_acc};
      mq_q  <= {last && mq_sgn_q, nxt_mq};
    end
  end

  assign acc_o  = acc_q;
  assign mq_o   = mq_q;
  assign busy_o = busy;
  assign dchk_o = dchk_q;

  assert_zero_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !nz && ((op == OP_MUL) || (op == OP_DIV))
    |=> $stable(acc_q) && $stable(mq_q) && !dchk_q);
  assert_mul_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && !div_q |=> acc_q[AS] == mq_q[MAG_W]);
  assert_mul_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mzero_hit |=> (acc_q[AW-1:0] == '0) && (mq_q[MAG_W-1:0] == '0) && !busy);
  assert_refuse_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse |=> $stable(acc_q) && $stable(mq_q) && dchk_q && !busy);
  assert_rem_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && div_q |=> acc_q[AW-1:0] < {2'b00, sr_q});
  assert_dchk_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(dchk_q));
endmodule

// File: tb/sm_muldiv_test.sv
`timescale 1ns/1ps
module sm_muldiv_test;
  localparam int MW = 35;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [7:0]    steps = 8'd0;
  logic [MW:0]   opnd = '0;
  logic [MW+2:0] acc;
  logic [MW:0]   mq;
  logic          busy, done, dchk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [MW+2:0] m_acc = '0;
  logic [MW:0]   m_mq = '0;
  logic          m_dchk = 1'b0;

  always #2 clk = ~clk;

  sm_muldiv uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .steps_i(steps),
    .operand_i(opnd), .acc_o(acc), .mq_o(mq), .busy_o(busy), .done_o(done),
    .dchk_o(dchk)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model; returns expected latency to done
  task automatic model(input logic [1:0] o, input logic [MW:0] d, input int n,
                       output int lat);
    logic [MW+1:0] am;
    logic [MW-1:0] qm;
    logic [MW+1:0] dv;
    logic sg, ge;
    lat = 1;
    m_dchk = 1'b0;
    am = m_acc[MW+1:0];
    qm = m_mq[MW-1:0];
    dv = {2'b00, d[MW-1:0]};
    case (o)
      2'd2: m_acc = {d[MW], 2'b00, d[MW-1:0]};
      2'd3: m_mq = d;
      2'd0: if (n != 0) begin
        sg = m_mq[MW] ^ d[MW];
        if (d[MW-1:0] == '0 || qm == '0) begin
          am = '0; qm = '0;
        end else begin
          lat = n + 1;
          for (int i = 0; i < n; i++) begin
            if (qm[0]) am = am + dv;
            qm = {am[0], qm[MW-1:1]};
            am = am >> 1;
          end
        end
        m_acc = {sg, am};
        m_mq = {sg, qm};
      end
      default: if (n != 0) begin
        if (am >= dv) m_dchk = 1'b1;
        else begin
          lat = n + 1;
          for (int i = 0; i < n; i++) begin
            am = {am[MW:0], qm[MW-1]};
            qm = {qm[MW-2:0], 1'b0};
            ge = am >= dv;
            if (ge) begin am = am - dv; qm[0] = 1'b1; end
          end
          m_mq = {m_acc[MW+2] ^ d[MW], qm};
          m_acc = {m_acc[MW+2], am};
        end
      end
    endcase
  endtask

  task automatic run_op(input logic [1:0] o, input logic [MW:0] d, input int n,
                        input string req);
    int lat, k;
    model(o, d, n, lat);
    @(negedge clk);
    start = 1'b1; op = o; opnd = d; steps = n[7:0];
    @(negedge clk);
    start = 1'b0;
    k = 1;
    if (lat > 1) chk(busy == 1'b1, "R8 busy during steps", 64'(busy), 64'd1);
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(k == lat, "R8 done latency", 64'(k), 64'(lat));
    chk(!busy, "R8 busy low at done", 64'(busy), 64'd0);
    chk(acc == m_acc, {req, " acc"}, 64'(acc), 64'(m_acc));
    chk(mq == m_mq, {req, " mq"}, 64'(mq), 64'(m_mq));
    chk(dchk == m_dchk, {req, " R10 dchk"}, 64'(dchk), 64'(m_dchk));
    @(negedge clk);
    chk(!done, "R8 single done pulse", 64'(done), 64'd0);
  endtask

  function automatic logic [MW:0] sw(input bit s, input longint m);
    return {s, m[MW-1:0]};
  endfunction

  task automatic t_reset;
    chk(acc == '0, "R1 acc", 64'(acc), 64'd0);
    chk(mq == '0, "R1 mq", 64'(mq), 64'd0);
    chk(!busy && !done && !dchk, "R1 flags", 64'({busy, done, dchk}), 64'd0);
  endtask

  task automatic t_load;
    run_op(2'd2, sw(1, 123), 0, "R2 load acc");
    chk(acc == {1'b1, 2'b00, 35'd123}, "R2 acc field", 64'(acc), 64'({1'b1, 2'b00, 35'd123}));
    run_op(2'd3, sw(0, 777), 0, "R2 load mq");
  endtask

  task automatic t_mul_full;
    run_op(2'd2, sw(0, 0), 0, "R2 setup");
    run_op(2'd3, sw(0, 12345), 0, "R2 setup");
    run_op(2'd0, sw(1, 678), 35, "R4 full multiply");
    chk(acc == {1'b1, 37'd0}, "R4 product high", 64'(acc), 64'({1'b1, 37'd0}));
    chk(mq == {1'b1, 35'd8369910}, "R4 product low", 64'(mq), 64'({1'b1, 35'd8369910}));
  endtask

  task automatic t_mul_misc;
    run_op(2'd2, sw(1, 7), 0, "R2 setup");
    run_op(2'd3, sw(1, 36'h5A5A5), 0, "R2 setup");
    run_op(2'd0, sw(1, 999), 12, "R4 partial multiply");
    run_op(2'd2, sw(0, 0), 0, "R2 setup");
    run_op(2'd3, sw(0, 64'h7_FFFF_FFFF), 0, "R2 setup");
    run_op(2'd0, sw(0, 64'h7_FFFF_FFFF), 35, "R4 max multiply");
    run_op(2'd0, sw(1, 5), 40, "R4 long multiply");
  endtask

  task automatic t_mul_zero;
    run_op(2'd2, sw(0, 55), 0, "R2 setup");
    run_op(2'd3, sw(1, 0), 0, "R2 setup");
    run_op(2'd0, sw(0, 77), 10, "R5 zero multiplier");
    chk(acc == {1'b1, 37'd0}, "R5 acc", 64'(acc), 64'({1'b1, 37'd0}));
    run_op(2'd3, sw(0, 9), 0, "R2 setup");
    run_op(2'd0, sw(1, 0), 10, "R5 zero operand");
  endtask

  task automatic t_zero_steps;
    run_op(2'd2, sw(1, 5000), 0, "R2 setup");
    run_op(2'd3, sw(0, 31), 0, "R2 setup");
    run_op(2'd0, sw(1, 3), 0, "R3 multiply zero steps");
    run_op(2'd1, sw(0, 10), 0, "R3 divide zero steps no check");
    chk(!dchk, "R3 no divide check", 64'(dchk), 64'd0);
  endtask

  task automatic t_div;
    run_op(2'd2, sw(1, 5), 0, "R2 setup");
    run_op(2'd3, sw(0, 123456789), 0, "R2 setup");
    run_op(2'd1, sw(0, 1000), 35, "R7 full divide");
    chk(mq == {1'b1, 35'd171922148}, "R7 quotient", 64'(mq), 64'({1'b1, 35'd171922148}));
    chk(acc == {1'b1, 37'd629}, "R7 remainder", 64'(acc), 64'({1'b1, 37'd629}));
    run_op(2'd2, sw(0, 40000), 0, "R2 setup");
    run_op(2'd3, sw(1, 64'h4_3210_FEDC), 0, "R2 setup");
    run_op(2'd1, sw(1, 54321), 7, "R7 partial divide");
  endtask

  task automatic t_refuse;
    run_op(2'd2, sw(0, 1000), 0, "R2 setup");
    run_op(2'd3, sw(1, 42), 0, "R2 setup");
    run_op(2'd1, sw(1, 1000), 35, "R6 equal magnitude refused");
    chk(dchk, "R6 divide check", 64'(dchk), 64'd1);
    repeat (3) @(negedge clk);
    chk(dchk, "R10 flag held", 64'(dchk), 64'd1);
    run_op(2'd1, sw(0, 1001), 3, "R6 just below accepted");
    chk(!dchk, "R10 flag cleared", 64'(dchk), 64'd0);
  endtask

  task automatic t_busy_ignore;
    int lat, k;
    run_op(2'd2, sw(0, 3), 0, "R2 setup");
    run_op(2'd3, sw(0, 1234567), 0, "R2 setup");
    model(2'd0, sw(0, 4321), 20, lat);
    @(negedge clk);
    start = 1'b1; op = 2'd0; opnd = sw(0, 4321); steps = 8'd20;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    @(negedge clk); k++;
    start = 1'b1; op = 2'd2; opnd = sw(1, 99999); steps = 8'd2;
    @(negedge clk); k++;
    start = 1'b0;
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(k == lat, "R9 length unchanged", 64'(k), 64'(lat));
    chk(acc == m_acc, "R9 acc not loaded", 64'(acc), 64'(m_acc));
    chk(mq == m_mq, "R9 mq", 64'(mq), 64'(m_mq));
    @(negedge clk);
    chk(!done, "R9 one done only", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load();
    t_mul_full();
    t_mul_misc();
    t_mul_zero();
    t_zero_steps();
    t_div();
    t_refuse();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule